// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a descriptor tree in memory, one level after another. A request carries a virtual address, a write flag and a privilege flag. A 64-bit root pointer, presented as two 32-bit words, names the first table. The first table holds 64-bit entries. The two lower tables hold 32-bit entries. A first-level entry may itself describe a large page, and the walk then stops early.

All descriptor reads and writes go through a single 32-bit memory port that has one request in flight. The port uses a request/acknowledge handshake. The walker checks each fetched descriptor for the expected type, for write protection and for supervisor-only access. When the walk succeeds, it writes back the used and modified bits. It raises `done` only after those writes have finished. A failed walk reports which check failed and at which level, and it writes nothing.

Top module: `ptw_walker`

## Requirements
- R1: Address split: bits 31:25 index the first table, bits 24:19 the second and bits 18:13 the third; bits 12:0 are the page offset. A first-table entry sits at root base + 8*index. Its attribute word is read at +0, then its address word at +4. Second- and third-table entries sit at base + 4*index. A base is the upper 28 bits of its pointer word, with the low 4 bits taken as zero. Every memory address is word aligned.
- R2: Type field in bits 1:0: 00 invalid, 01 page, 10 short-table pointer, 11 long-table pointer. The root pointer must be of type 11. A first-level entry may be 01 or 10, a second-level entry must be 10, and a third-level entry must be 01.
- R3: When a first-level entry has type 01, the walk ends after two reads. The physical address is bits 31:25 of its address word joined with virtual bits 24:0.
- R4: A full walk makes four reads. The physical address is bits 31:13 of the third-level word joined with virtual bits 12:0.
- R5: A type fault gives `fault`=1 and `fault_code`={2'b01, level}, where level is 0 for the root, 1 for the first level, 2 for the second and 3 for the third. `paddr` is then 0, no memory write is made, and no deeper level is read.
- R6: A write request faults with code {2'b10, level} at the first descriptor on the path that has bit 2 (write protect) set.
- R7: A user request (`req_super`=0) faults with code {2'b11, level} when bit 8 (supervisor only) is set in the root high word or the first-level attribute word. Priority within one level is type, then supervisor, then write protect.
- R8: After a successful walk, every visited descriptor word whose bit 3 (used) is clear is rewritten with bit 3 set. The writes go in level order: first, second, then third. Words whose used bit is already set are not rewritten.
- R9: A successful write request also sets bit 4 (modified) in the page descriptor: the third-level word, or the first-level attribute word for a large page.
- R10: With memory acknowledging on the cycle after it sees a request, `done` is a one-cycle pulse. For R reads it comes 2R+1 cycles after the accepted request on a fault, and 2R+3W+3 cycles after it on success with W writes. A request raised while `busy` is high is ignored.
- R11: `mem_req` stays high with a stable address and direction until `mem_ack`. It is low whenever the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation; taken only when idle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| req_super | input | 1 | 1 for a supervisor access |
| root_hi | input | 32 | Root pointer attribute word |
| root_lo | input | 32 | Root pointer address word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk failed; valid with done |
| fault_code | output | 4 | {kind, level}; 0 on success |
| paddr | output | 32 | Physical address; valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
A fault is due 2R+1 cycles after the request edge. A success is due 2R+3W+3 cycles after it. The expected read and write counts come from the table contents the bench itself set up. The bench stamps the cycle at which each request was taken, and the monitor compares the measured latency with that formula when `done` appears. The monitor also compares the memory traffic the model counted against the expected counts. Every output is sampled on the falling edge, so each value is read one half cycle after the edge that registered it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {DT_INV = 2'b00, DT_PAGE = 2'b01, DT_SHORT = 2'b10, DT_LONG = 2'b11} dtype_e;
  typedef enum logic [1:0] {FK_NONE = 2'b00, FK_TYPE = 2'b01, FK_WP = 2'b10, FK_SUPV = 2'b11} fkind_e;
  typedef enum logic [2:0] {S_IDLE, S_START, S_RD_AHI, S_RD_ALO, S_RD_B, S_RD_C, S_PLAN, S_WB} wstate_e;
  localparam int BIT_WP   = 2;
  localparam int BIT_USED = 3;
  localparam int BIT_MOD  = 4;
  localparam int BIT_SUPV = 8;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int IA = 7,
  parameter int IB = 6,
  parameter int IC = 6
) (
  input  logic [31:0] va,
  input  logic [27:0] root_base,
  input  logic [27:0] a_base,
  input  logic [27:0] b_base,
  output logic [31:0] a_hi_addr,
  output logic [31:0] a_lo_addr,
  output logic [31:0] b_addr,
  output logic [31:0] c_addr
);
  localparam int OFF_W = 32 - IA - IB - IC;
  logic [IA-1:0] idx_a;
  logic [IB-1:0] idx_b;
  logic [IC-1:0] idx_c;
  logic [OFF_W-1:0] unused_off;

  assign idx_a = va[31 -: IA];
  assign idx_b = va[31-IA -: IB];
  assign idx_c = va[OFF_W +: IC];
  assign unused_off = va[OFF_W-1:0];

  assign a_hi_addr = {root_base, 4'b0000} + {{(29-IA){1'b0}}, idx_a, 3'b000};
  assign a_lo_addr = a_hi_addr + 32'd4;
  assign b_addr    = {a_base, 4'b0000} + {{(30-IB){1'b0}}, idx_b, 2'b00};
  assign c_addr    = {b_base, 4'b0000} + {{(30-IC){1'b0}}, idx_c, 2'b00};
endmodule

// File: rtl/ptw_desc_check.sv
module ptw_desc_check
  import ptw_pkg::*;
(
  input  logic [1:0] dt,
  input  logic       wp,
  input  logic       supv,
  input  logic [1:0] level,
  input  logic       wr,
  input  logic       sup,
  output fkind_e     kind,
  output logic       is_page
);
  logic type_ok;
  logic is_long;

  always_comb begin
    case (level)
      2'd0:    type_ok = (dt == DT_LONG);
      2'd1:    type_ok = (dt == DT_PAGE) || (dt == DT_SHORT);
      2'd2:    type_ok = (dt == DT_SHORT);
      default: type_ok = (dt == DT_PAGE);
    endcase
  end

  assign is_long = (level == 2'd0) || (level == 2'd1);
  assign is_page = (dt == DT_PAGE);

  always_comb begin
    if (!type_ok)                 kind = FK_TYPE;
    else if (is_long && supv && !sup) kind = FK_SUPV;
    else if (wp && wr)            kind = FK_WP;
    else                          kind = FK_NONE;
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int IA = 7,
  parameter int IB = 6,
  parameter int IC = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic        req_write,
  input  logic        req_super,
  input  logic [31:0] root_hi,
  input  logic [31:0] root_lo,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [3:0]  fault_code,
  output logic [31:0] paddr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int OFF_W = 32 - IA - IB - IC;
  localparam int PN_W  = 32 - OFF_W;

  wstate_e     st;
  logic [31:0] va_r;
  logic        wr_r, sup_r, a_page_r;
  logic [31:0] a_hi_r, b_w_r, c_w_r;
  logic [27:0] a_lo_r;
  logic [2:0]  pend;

  // descriptor check, fed from the word for the current level
  logic [31:0] chk_attr;
  logic [1:0]  chk_level;
  fkind_e      chk_kind;
  logic        chk_page;

  always_comb begin
    case (st)
      S_START:  begin chk_attr = root_hi;   chk_level = 2'd0; end
      S_RD_ALO: begin chk_attr = a_hi_r;    chk_level = 2'd1; end
      S_RD_B:   begin chk_attr = mem_rdata; chk_level = 2'd2; end
      S_RD_C:   begin chk_attr = mem_rdata; chk_level = 2'd3; end
      default:  begin chk_attr = root_hi;   chk_level = 2'd0; end
    endcase
  end

  ptw_desc_check u_chk (
    .dt(chk_attr[1:0]), .wp(chk_attr[BIT_WP]), .supv(chk_attr[BIT_SUPV]),
    .level(chk_level), .wr(wr_r), .sup(sup_r), .kind(chk_kind), .is_page(chk_page)
  );

  // entry addresses; a base word arriving this cycle is used directly
  logic [27:0] a_base_src, b_base_src;
  logic [31:0] a_hi_addr, a_lo_addr, b_addr, c_addr;
  assign a_base_src = (st == S_RD_ALO) ? mem_rdata[31:4] : a_lo_r;
  assign b_base_src = (st == S_RD_B)   ? mem_rdata[31:4] : b_w_r[31:4];

  ptw_addr_gen #(.IA(IA), .IB(IB), .IC(IC)) u_agen (
    .va(va_r), .root_base(root_lo[31:4]), .a_base(a_base_src), .b_base(b_base_src),
    .a_hi_addr(a_hi_addr), .a_lo_addr(a_lo_addr), .b_addr(b_addr), .c_addr(c_addr)
  );

  // next write-back target, lowest level first
  logic [31:0] wb_addr, wb_data;
  logic [2:0]  wb_bit;
  always_comb begin
    wb_addr = a_hi_addr;
    wb_data = a_hi_r | (32'd1 << BIT_USED) | ((a_page_r && wr_r) ? (32'd1 << BIT_MOD) : 32'd0);
    wb_bit  = 3'b001;
    if (!pend[0] && pend[1]) begin
      wb_addr = b_addr;
      wb_data = b_w_r | (32'd1 << BIT_USED);
      wb_bit  = 3'b010;
    end else if (!pend[0] && !pend[1]) begin
      wb_addr = c_addr;
      wb_data = c_w_r | (32'd1 << BIT_USED) | (wr_r ? (32'd1 << BIT_MOD) : 32'd0);
      wb_bit  = 3'b100;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{root_hi[31:9], root_hi[7:3], root_lo[3:0], chk_attr[31:9], chk_attr[7:3]};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; va_r <= '0; wr_r <= 1'b0; sup_r <= 1'b0; a_page_r <= 1'b0;
      a_hi_r <= '0; a_lo_r <= '0; b_w_r <= '0; c_w_r <= '0; pend <= '0;
      done <= 1'b0; fault <= 1'b0; fault_code <= '0; paddr <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_r <= req_vaddr; wr_r <= req_write; sup_r <= req_super;
          a_page_r <= 1'b0; pend <= '0;
          fault <= 1'b0; fault_code <= '0; paddr <= '0;
          st <= S_START;
        end
        S_START: if (chk_kind != FK_NONE) begin
          done <= 1'b1; fault <= 1'b1; fault_code <= {chk_kind, chk_level}; st <= S_IDLE;
        end else begin
          mem_req <= 1'b1; mem_we <= 1'b0; mem_addr <= a_hi_addr; st <= S_RD_AHI;
        end
        S_RD_AHI: if (mem_ack) begin
          a_hi_r <= mem_rdata; mem_addr <= a_lo_addr; st <= S_RD_ALO;
        end
        S_RD_ALO: if (mem_ack) begin
          a_lo_r <= mem_rdata[31:4];
          if (chk_kind != FK_NONE) begin
            mem_req <= 1'b0; done <= 1'b1; fault <= 1'b1;
            fault_code <= {chk_kind, chk_level}; st <= S_IDLE;
          end else if (chk_page) begin
            mem_req <= 1'b0; a_page_r <= 1'b1;
            paddr <= {mem_rdata[31 -: IA], va_r[31-IA:0]}; st <= S_PLAN;
          end else begin
            mem_addr <= b_addr; st <= S_RD_B;
          end
        end
        S_RD_B: if (mem_ack) begin
          b_w_r <= mem_rdata;
          if (chk_kind != FK_NONE) begin
            mem_req <= 1'b0; done <= 1'b1; fault <= 1'b1;
            fault_code <= {chk_kind, chk_level}; st <= S_IDLE;
          end else begin
            mem_addr <= c_addr; st <= S_RD_C;
          end
        end
        S_RD_C: if (mem_ack) begin
          c_w_r <= mem_rdata; mem_req <= 1'b0;
          if (chk_kind != FK_NONE) begin
            done <= 1'b1; fault <= 1'b1; fault_code <= {chk_kind, chk_level}; st <= S_IDLE;
          end else begin
            paddr <= {mem_rdata[31 -: PN_W], va_r[OFF_W-1:0]}; st <= S_PLAN;
          end
        end
        S_PLAN: begin
          pend[0] <= !a_hi_r[BIT_USED] || (a_page_r && wr_r && !a_hi_r[BIT_MOD]);
          pend[1] <= !a_page_r && !b_w_r[BIT_USED];
          pend[2] <= !a_page_r && (!c_w_r[BIT_USED] || (wr_r && !c_w_r[BIT_MOD]));
          st <= S_WB;
        end
        S_WB: begin
          if (mem_req && mem_ack) begin
            mem_req <= 1'b0; mem_we <= 1'b0; pend <= pend & ~wb_bit;
          end else if (!mem_req && pend != 3'b000) begin
            mem_req <= 1'b1; mem_we <= 1'b1; mem_addr <= wb_addr; mem_wdata <= wb_data;
          end else if (!mem_req) begin
            done <= 1'b1; st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R11
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R1
  AST_WB_USED: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[BIT_USED]); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (rst)
    done && fault |-> paddr == 32'd0 && fault_code[3:2] != 2'b00); // R5
  AST_OK_CODE: assert property (@(posedge clk) disable iff (rst)
    done && !fault |-> fault_code == 4'd0); // R4
endmodule

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] root_hi = 32'h3, root_lo = 32'h0;
  logic        busy, done, fault, mem_req, mem_we;
  logic [3:0]  fault_code;
  logic [31:0] paddr, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  ptw_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .root_hi(root_hi), .root_lo(root_lo),
    .busy(busy), .done(done), .fault(fault), .fault_code(fault_code), .paddr(paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] mem [0:1023];
  int rd_cnt = 0, wr_cnt = 0, cyc = 0;
  int checks = 0, failures = 0;
  int rd_base = 0, wr_base = 0, t0 = 0, done_cnt = 0, runs = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin mem[mem_addr[11:2]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
      else begin mem_rdata <= mem[mem_addr[11:2]]; rd_cnt <= rd_cnt + 1; end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    string tag; logic flt; logic [3:0] code; logic [31:0] pa; int rd; int wr; int lat;
  } exp_t;
  exp_t q[$];

  // monitor: pops and compares as each result appears
  always @(negedge clk) begin
    if (!rst && done) begin
      done_cnt++;
      if (q.size() == 0) begin
        chk("R10 unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " fault"}, {31'd0, fault}, {31'd0, e.flt});
        chk({e.tag, " code"}, {28'd0, fault_code}, {28'd0, e.code});
        chk({e.tag, " paddr"}, paddr, e.pa);
        chk({e.tag, " reads"}, rd_cnt - rd_base, e.rd);
        chk({e.tag, " writes"}, wr_cnt - wr_base, e.wr);
        chk({e.tag, " R10 latency"}, cyc - t0, e.lat);
      end
    end
  end

  task automatic run(string tag, logic [31:0] va, logic w, logic s, logic flt,
                     logic [3:0] code, logic [31:0] pa, int rd, int wrn, bit poke = 1'b0);
    exp_t e;
    e.tag = tag; e.flt = flt; e.code = code; e.pa = pa; e.rd = rd; e.wr = wrn;
    e.lat = flt ? 2*rd + 1 : 2*rd + 3*wrn + 3;
    q.push_back(e);
    runs++;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_super = s;
    rd_base = rd_cnt; wr_base = wr_cnt;
    @(negedge clk);
    req_valid = 1'b0; t0 = cyc;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h0600_0000; req_write = 1'b1; req_super = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    // first table at 0x000, second at 0x400, third at 0x500
    mem[32'h008 >> 2] = 32'h0000_0002; mem[32'h00C >> 2] = 32'h0000_0400;
    mem[32'h010 >> 2] = 32'h0000_0001; mem[32'h014 >> 2] = 32'h7E00_0000;
    mem[32'h020 >> 2] = 32'h0000_0003;
    mem[32'h028 >> 2] = 32'h0000_000A; mem[32'h02C >> 2] = 32'h0000_0400;
    mem[32'h030 >> 2] = 32'h0000_010A; mem[32'h034 >> 2] = 32'h0000_0400;
    mem[32'h408 >> 2] = 32'h0000_0502;
    mem[32'h418 >> 2] = 32'h0000_0506;
    mem[32'h50C >> 2] = 32'hABCD_E001;
    mem[32'h514 >> 2] = 32'h1111_2005;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset mem_req", {31'd0, mem_req}, 32'd0);

    run("R1 R4 R8 full read", 32'h0210_6123, 0, 0, 0, 4'h0, 32'hABCD_E123, 4, 3);
    chk("R8 first used", mem[32'h008 >> 2], 32'h0000_000A);
    chk("R8 second used", mem[32'h408 >> 2], 32'h0000_050A);
    chk("R8 third used", mem[32'h50C >> 2], 32'hABCD_E009);
    run("R8 all used no write", 32'h0210_6123, 0, 0, 0, 4'h0, 32'hABCD_E123, 4, 0);
    run("R9 write sets modified", 32'h0210_6123, 1, 0, 0, 4'h0, 32'hABCD_E123, 4, 1);
    chk("R9 third modified", mem[32'h50C >> 2], 32'hABCD_E019);
    run("R3 R9 large page write", 32'h0555_ABCD, 1, 1, 0, 4'h0, 32'h7F55_ABCD, 2, 1);
    chk("R3 R9 first word rmw", mem[32'h010 >> 2], 32'h0000_0019);
    run("R2 R5 first invalid", 32'h0600_0000, 0, 0, 1, 4'h5, 32'h0, 2, 0);
    run("R2 R5 first long type", 32'h0800_0000, 0, 0, 1, 4'h5, 32'h0, 2, 0);
    run("R2 R5 second invalid", 32'h0A28_0000, 0, 0, 1, 4'h6, 32'h0, 3, 0);
    run("R2 R5 third invalid", 32'h0210_8000, 0, 0, 1, 4'h7, 32'h0, 4, 0);
    run("R6 second protect", 32'h0A30_0000, 1, 0, 1, 4'hA, 32'h0, 3, 0);
    run("R6 third protect", 32'h0210_A0AA, 1, 0, 1, 4'hB, 32'h0, 4, 0);
    chk("R5 no write on fault", mem[32'h514 >> 2], 32'h1111_2005);
    run("R6 R8 protect read ok", 32'h0210_A0AA, 0, 0, 0, 4'h0, 32'h1111_20AA, 4, 1);
    chk("R8 third used set", mem[32'h514 >> 2], 32'h1111_200D);
    run("R7 first supervisor user", 32'h0C10_6123, 0, 0, 1, 4'hD, 32'h0, 2, 0);
    run("R7 first supervisor ok", 32'h0C10_6123, 0, 1, 0, 4'h0, 32'hABCD_E123, 4, 0);

    root_hi = 32'h0000_0107;
    run("R7 root supervisor", 32'h0210_6123, 0, 0, 1, 4'hC, 32'h0, 0, 0);
    run("R6 root protect", 32'h0210_6123, 1, 1, 1, 4'h8, 32'h0, 0, 0);
    root_hi = 32'h0000_0002;
    run("R2 R5 root type", 32'h0210_6123, 0, 0, 1, 4'h4, 32'h0, 0, 0);
    root_hi = 32'h0000_0003;

    run("R10 busy ignores request", 32'h0210_6123, 0, 0, 0, 4'h0, 32'hABCD_E123, 4, 0, 1'b1);
    repeat (30) @(negedge clk);
    chk("R10 one done per run", done_cnt, runs);
    chk("R11 idle port", {31'd0, mem_req}, 32'd0);
    finish_run();
  end
endmodule